// File: doc/BRIEF.md
# Iterated Von Neumann Pair Splitter

This block is one processing element of an iterated Von Neumann debiasing tree. It reads a serial bit stream qualified by a strobe. It groups the bits it accepts into consecutive pairs that do not overlap. For every completed pair it emits bits on three serial output streams, each with its own one-cycle valid pulse.

The first stream carries the unbiased Von Neumann bit. The second carries the parity of the pair. The third carries the residual bit left over from equal pairs. A plain corrector would throw the parity and residual streams away. Here they are exposed so that a downstream element of the same kind can process them again and recover more entropy.

The block holds one stored first bit and one pair-phase flag. Its outputs are registered. It applies no backpressure and does no buffering.

Top module: `ivn_pair_splitter`

## Requirements
- R1: A bit is accepted only in a cycle where `in_vld` is high. Cycles with `in_vld` low change no state and produce no output, whatever `in_bit` holds.
- R2: Accepted bits form consecutive non-overlapping pairs. The first bit accepted after reset opens a pair, and the next accepted bit closes it.
- R3: A pair written (first, second) = (0,1) gives `vn_bit`=1 and a pulse on `vn_vld`. The pair (1,0) gives `vn_bit`=0 and a pulse on `vn_vld`. The pairs (0,0) and (1,1) give no pulse on `vn_vld`.
- R4: The pair (1,1) gives `rs_bit`=1 and the pair (0,0) gives `rs_bit`=0, each with a pulse on `rs_vld`. Unequal pairs give no pulse on `rs_vld`.
- R5: Every pair gives one pulse on `xr_vld`. The value `xr_bit` is 1 when the two bits differ and 0 when they are equal.
- R6: For each pair, exactly one of `vn_vld` and `rs_vld` pulses, and it pulses in the same cycle as `xr_vld`.
- R7: The output valids go high for exactly one cycle. That cycle is the one that follows the clock edge which accepted the second bit of the pair.
- R8: A synchronous reset (`rst` high at a clock edge) drops all three valids in the next cycle. It also clears the pair phase, so a bit presented together with reset is discarded and the next accepted bit opens a new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Raw input bit |
| in_vld | input | 1 | Qualifies `in_bit` in this cycle |
| vn_bit | output | 1 | Von Neumann output bit |
| vn_vld | output | 1 | One-cycle valid for `vn_bit` |
| xr_bit | output | 1 | Pair parity bit |
| xr_vld | output | 1 | One-cycle valid for `xr_bit` |
| rs_bit | output | 1 | Residual bit of an equal pair |
| rs_vld | output | 1 | One-cycle valid for `rs_bit` |

## Verification
The clock edge that closes a pair loads the output registers. If `in_vld` is also high in the next cycle, the first bit of the following pair is stored during the very cycle in which the output pulse is visible, so pair completion and pair opening overlap.

The bench forces this overlap with back-to-back strobes in an exhaustive sweep. That sweep covers all four pair values, with zero to three idle cycles inside each pair and between pairs. A second stimulus runs a long pseudo-random stream with random gaps.

Reset is also asserted in the cycle that presents a second bit, and again after a lone first bit. Both cases check that no pulse appears and that the new pairing starts from the next accepted bit. Every cycle is judged against a pair model in the bench, which tracks phase and the stored bit on its own.

// File: rtl/ivn_pkg.sv
package ivn_pkg;

   // One completed pair in arrival order.
   typedef struct packed {
      logic first;
      logic second;
   } ivn_pair_t;

   // Decoded view of a pair.
   typedef struct packed {
      logic unequal;   // parity of the pair
      logic bit_val;   // data bit for the VN or residual stream
   } ivn_dec_t;

   // Both the VN bit of an unequal pair and the residual bit of an equal
   // pair are the second bit, so one value serves both streams.
   function automatic ivn_dec_t ivn_decode(input ivn_pair_t p);
      ivn_dec_t d;
      d.unequal = p.first ^ p.second;
      d.bit_val = p.second;
      return d;
   endfunction

endpackage

// File: rtl/ivn_pair_collect.sv
module ivn_pair_collect
   import ivn_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      bit_i,
   input  logic      bit_vld,
   output logic      pair_done,
   output ivn_pair_t pair
);

   logic phase_q;   // 1: holding the first bit of a pair
   logic first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 1'b0;
         first_q <= 1'b0;
      end else if (bit_vld) begin
         phase_q <= ~phase_q;
         if (!phase_q) first_q <= bit_i;
      end
   end

   assign pair_done   = bit_vld & phase_q;
   assign pair.first  = first_q;
   assign pair.second = bit_i;

   // R2: an opening bit is followed by a closing bit at the next strobe
   a_r2_opens_then_closes: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !pair_done) |=> (!bit_vld || pair_done));

   // R2: two pairs cannot close on consecutive edges
   a_r2_no_back_to_back_close: assert property (@(posedge clk) disable iff (rst)
      pair_done |=> !pair_done);

endmodule

// File: rtl/ivn_out_stage.sv
module ivn_out_stage
   import ivn_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      pair_done,
   input  ivn_pair_t pair,
   output logic      vn_bit,
   output logic      vn_vld,
   output logic      xr_bit,
   output logic      xr_vld,
   output logic      rs_bit,
   output logic      rs_vld
);

   ivn_dec_t dec;
   logic     data_q;
   logic     par_q;
   logic     vn_vld_q;
   logic     rs_vld_q;
   logic     xr_vld_q;

   assign dec = ivn_decode(pair);

   always_ff @(posedge clk) begin
      if (rst) begin
         vn_vld_q <= 1'b0;
         rs_vld_q <= 1'b0;
         xr_vld_q <= 1'b0;
      end else begin
         vn_vld_q <= pair_done &  dec.unequal;
         rs_vld_q <= pair_done & ~dec.unequal;
         xr_vld_q <= pair_done;
      end
   end

   // Data registers hold their value between pairs.
   always_ff @(posedge clk) begin
      if (pair_done) begin
         data_q <= dec.bit_val;
         par_q  <= dec.unequal;
      end
   end

   assign vn_bit = data_q;
   assign rs_bit = data_q;
   assign xr_bit = par_q;
   assign vn_vld = vn_vld_q;
   assign rs_vld = rs_vld_q;
   assign xr_vld = xr_vld_q;

   // R6: parity pulse always comes with exactly one data stream
   a_r6_one_side: assert property (@(posedge clk) disable iff (rst)
      xr_vld_q == (vn_vld_q ^ rs_vld_q) && !(vn_vld_q && rs_vld_q));

   // R5: parity agrees with the stream chosen
   a_r5_parity_matches: assert property (@(posedge clk) disable iff (rst)
      xr_vld_q |-> (par_q == vn_vld_q));

endmodule

// File: rtl/ivn_pair_splitter.sv
module ivn_pair_splitter
   import ivn_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic in_bit,
   input  logic in_vld,
   output logic vn_bit,
   output logic vn_vld,
   output logic xr_bit,
   output logic xr_vld,
   output logic rs_bit,
   output logic rs_vld
);

   logic      pair_done;
   ivn_pair_t pair;

   ivn_pair_collect i_collect (
      .clk       (clk),
      .rst       (rst),
      .bit_i     (in_bit),
      .bit_vld   (in_vld),
      .pair_done (pair_done),
      .pair      (pair)
   );

   ivn_out_stage i_out (
      .clk       (clk),
      .rst       (rst),
      .pair_done (pair_done),
      .pair      (pair),
      .vn_bit    (vn_bit),
      .vn_vld    (vn_vld),
      .xr_bit    (xr_bit),
      .xr_vld    (xr_vld),
      .rs_bit    (rs_bit),
      .rs_vld    (rs_vld)
   );

   // R1: an output pulse needs a strobe on the previous edge
   a_r1_needs_strobe: assert property (@(posedge clk) disable iff (rst)
      xr_vld |-> $past(in_vld));

   // R3: the VN bit is the closing bit of the pair
   a_r3_vn_value: assert property (@(posedge clk) disable iff (rst)
      vn_vld |-> (vn_bit == $past(in_bit)));

   // R4: the residual bit is the closing bit of the pair
   a_r4_rs_value: assert property (@(posedge clk) disable iff (rst)
      rs_vld |-> (rs_bit == $past(in_bit)));

   // R7: pulses last a single cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      xr_vld |=> !xr_vld);

   // R8: reset silences every valid on the next cycle
   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (!xr_vld && !vn_vld && !rs_vld));

endmodule

// File: tb/test_ivn_pair_splitter.sv
module test_ivn_pair_splitter;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_bit = 1'b0;
   logic in_vld = 1'b0;
   logic vn_bit, vn_vld, xr_bit, xr_vld, rs_bit, rs_vld;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   // bench model
   bit  m_phase = 1'b0;
   bit  m_first = 1'b0;
   bit  e_vn_vld = 1'b0, e_xr_vld = 1'b0, e_rs_vld = 1'b0;
   bit  e_vn = 1'b0, e_xr = 1'b0, e_rs = 1'b0;
   bit  armed = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ivn_pair_splitter i_ivn_pair_splitter (
      .clk(clk), .rst(rst), .in_bit(in_bit), .in_vld(in_vld),
      .vn_bit(vn_bit), .vn_vld(vn_vld), .xr_bit(xr_bit), .xr_vld(xr_vld),
      .rs_bit(rs_bit), .rs_vld(rs_vld));

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
      end
   endtask

   // Compare the outputs against the model's expectation for this cycle.
   task automatic check_now(input string tag);
      chk(tag, "xr_vld", xr_vld, e_xr_vld);
      chk(tag, "vn_vld", vn_vld, e_vn_vld);
      chk(tag, "rs_vld", rs_vld, e_rs_vld);
      if (e_xr_vld) chk(tag, "xr_bit", xr_bit, e_xr);
      if (e_vn_vld) chk(tag, "vn_bit", vn_bit, e_vn);
      if (e_rs_vld) chk(tag, "rs_bit", rs_bit, e_rs);
   endtask

   // One cycle: check at the falling edge, then drive and predict.
   task automatic step(input string tag, input bit r, input bit v, input bit b);
      @(negedge clk);
      if (armed) check_now(tag);
      rst = r; in_vld = v; in_bit = b;
      e_vn_vld = 0; e_xr_vld = 0; e_rs_vld = 0;
      if (r) begin
         m_phase = 0;
      end else if (v) begin
         if (m_phase) begin
            e_xr_vld = 1;
            e_xr     = m_first ^ b;
            e_vn_vld = (m_first != b);
            e_rs_vld = (m_first == b);
            e_vn     = b;
            e_rs     = b;
            m_phase  = 0;
         end else begin
            m_first = b;
            m_phase = 1;
         end
      end
      armed = 1'b1;
   endtask

   task automatic idle(input string tag, input int n);
      for (int k = 0; k < n; k++) step(tag, 0, 0, k[0]);   // R1: junk data with no strobe
   endtask

   initial begin
      bit [15:0] lfsr;
      step("R8", 1, 0, 0);
      step("R8", 1, 1, 1);
      step("R8", 0, 0, 0);   // reset state: all valids low
      step("R8", 0, 0, 0);

      // R3 R4 R5 R6 R7 R2: exhaustive pair values and gap lengths
      for (int p = 0; p < 4; p++)
         for (int g1 = 0; g1 < 4; g1++)
            for (int g2 = 0; g2 < 4; g2++) begin
               step("R2", 0, 1, p[1]);
               idle("R1", g1);
               step("R3", 0, 1, p[0]);
               idle("R7", g2);
            end
      idle("R7", 2);

      // R8: reset with a dangling first bit, then a fresh pair 0,1
      step("R8", 0, 1, 1);
      step("R8", 1, 0, 0);
      step("R8", 0, 1, 0);
      step("R8", 0, 1, 1);
      step("R8", 0, 0, 0);

      // R8: reset coinciding with the closing bit
      step("R8", 0, 1, 0);
      step("R8", 1, 1, 0);
      step("R8", 0, 1, 1);
      step("R8", 0, 1, 1);
      step("R4", 0, 0, 0);

      // R1 R5 R6: pseudo-random stream with random gaps
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step("R5", 0, lfsr[3] | lfsr[7], lfsr[0]);
      end
      idle("R6", 3);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule